// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Adapter

This block connects a processor bus to one asynchronous serial line in each direction. Software reaches four 8-bit registers through a single select bit and the access direction. With select 0, a write loads the control register and a read returns the status register. With select 1, a write loads the transmit holding register and a read returns the last received character. Every access takes exactly one cycle and there is no back-pressure. Status flags change as a side effect of data-register accesses, so software does not need extra write cycles to clear them.

Characters are framed as follows: one start bit at space (0), then 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two stop bits at mark (1). Bit timing comes from two clock-enable inputs, one for the transmitter and one for the receiver. Each bit lasts 1, 16 or 64 enable pulses, as the control register selects. In the 16 and 64 modes the receiver confirms the start bit at its midpoint and then samples every later bit at its centre. A level interrupt request combines the receive and transmit conditions that software has enabled. One transmit-control code holds the line at space to send a break.

Top module: `aser_adapter`

## Requirements
- R1: Select 0 with write loads control, and select 0 with read returns status. Select 1 with write loads the transmit holding register, and select 1 with read returns received data. A 7-bit character reads back with bit 7 = 0.
- R2: Control bits [1:0] set the ticks per bit: 00 = 1, 01 = 16, 10 = 64. The value 11 is master reset. It clears status bits 0, 4, 5 and 6, sets status bit 1, holds both serial machines idle and holds the transmit line at 1. Reset loads control with 0x03, so status reads 0x02 after reset.
- R3: Control bits [4:2] select the word format, written as data bits, parity and stop bits. 000 = 7 data, even parity, 2 stop. 001 = 7, odd, 2. 010 = 7, even, 1. 011 = 7, odd, 1. 100 = 8, no parity, 2. 101 = 8, none, 1. 110 = 8, even, 1. 111 = 8, odd, 1.
- R4: The transmitter sends one frame per character: a 0 start bit, the data bits LSB first, the parity bit (if enabled) and the stop bits at 1. Each bit lasts one bit period.
- R5: The receiver detects the start bit, samples each later bit at its centre, and loads the character into the receive register. It then sets status bit 0 (receive full).
- R6: In the 16 and 64 modes, a low pulse on the receive line shorter than half a bit is ignored. It loads no character.
- R7: A received parity bit that does not match the selected parity sets status bit 6.
- R8: A stop bit sampled at 0 sets status bit 4 (framing error).
- R9: A character that completes while receive full is still set is discarded, and status bit 5 (overrun) is set. The earlier character stays readable.
- R10: Reading the received data clears status bits 0, 4, 5 and 6.
- R11: Status bit 1 (transmit empty) clears when the transmit holding register is written. It sets again when the character moves into the shifter.
- R12: Control bits [6:5] = 11 drive the transmit line to 0 continuously for as long as that code is held.
- R13: The irq output is high while either of these is true: control bit 7 is set and status bit 0 or bit 5 is set; or control bits [6:5] = 01 and status bit 1 is set. Status bit 7 reads the same value as irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |
| rx_tick | input | 1 | Receive bit-rate clock enable |
| tx_tick | input | 1 | Transmit bit-rate clock enable |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |

## Verification
A table of characters is run through both directions. The table covers all three tick ratios and formats with 7 and 8 data bits, even, odd and no parity, and one or two stop bits. These cases separate errors in bit order, in the data-width mask and in the parity sense from errors in bit-period counting. Directed frames then carry a wrong parity bit, a stop bit at 0, two characters with no read between them, and a short low glitch. Each frame sets exactly one distinct flag, or none at all, so the flag logic and the start-bit midpoint check are observed one at a time. Interrupt, break and master-reset cases check how the control fields act on irq and the transmit line.

// File: rtl/aser_pkg.sv
package aser_pkg;
  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  typedef enum logic [1:0] {
    DIV_ONE  = 2'b00,
    DIV_LO_S = 2'b01,
    DIV_HI_S = 2'b10,
    DIV_MRST = 2'b11
  } div_t;

  function automatic fmt_t fmt_decode(input logic [2:0] code);
    fmt_t f;
    case (code)
      3'd0:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
      3'd1:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
      3'd2:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      3'd3:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
      3'd4:    f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
      3'd5:    f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
      3'd6:    f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      default: f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/aser_rx.sv
module aser_rx
  import aser_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tick,
  input  div_t       div,
  input  logic       eight,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rx_in,
  output logic       done,
  output logic [7:0] data,
  output logic       par_err,
  output logic       frm_err
);
  localparam int CW = $clog2(DIV_HI) + 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
  rx_state_t       st;
  logic [1:0]      sync;
  logic            rxs;
  logic [CW-1:0]   cnt, period, half;
  logic [3:0]      idx, nd, last;
  logic [9:0]      bits;
  logic [7:0]      dmask;

  assign rxs = sync[1];

  always_comb begin
    case (div)
      DIV_LO_S: period = CW'(DIV_LO);
      DIV_HI_S: period = CW'(DIV_HI);
      default:  period = CW'(1);
    endcase
    half  = period >> 1;
    nd    = eight ? 4'd8 : 4'd7;
    last  = nd + {3'b000, par_en};
    dmask = eight ? bits[7:0] : {1'b0, bits[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      bits    <= '0;
      done    <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      sync <= {sync[0], rx_in};
      done <= 1'b0;
      if (hold) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!rxs) begin
            cnt <= '0;
            idx <= '0;
            st  <= (half == '0) ? RX_BITS : RX_START;
          end
          RX_START: begin
            if (cnt == half - CW'(1)) begin
              cnt <= '0;
              st  <= rxs ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          RX_BITS: begin
            if (cnt == period - CW'(1)) begin
              cnt       <= '0;
              bits[idx] <= rxs;
              if (idx == last) begin
                done    <= 1'b1;
                st      <= RX_IDLE;
                data    <= dmask;
                par_err <= par_en & ((^dmask) ^ par_odd ^ bits[nd]);
                frm_err <= ~rxs;
              end else begin
                idx <= idx + 4'd1;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R5
  done_only_from_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == RX_BITS));
endmodule

// File: rtl/aser_tx.sv
module aser_tx
  import aser_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tick,
  input  logic       brk,
  input  div_t       div,
  input  fmt_t       fmt,
  input  logic       have_data,
  input  logic [7:0] tdata,
  output logic       load,
  output logic       tx_out
);
  localparam int CW = $clog2(DIV_HI) + 1;
  localparam int FW = 12;

  logic [CW-1:0] cnt, period;
  logic [FW-1:0] sh, frame;
  logic [3:0]    left, nbits, nd;
  logic          busy, par;

  always_comb begin
    case (div)
      DIV_LO_S: period = CW'(DIV_LO);
      DIV_HI_S: period = CW'(DIV_HI);
      default:  period = CW'(1);
    endcase
    nd    = fmt.eight ? 4'd8 : 4'd7;
    par   = (^(tdata & (fmt.eight ? 8'hFF : 8'h7F))) ^ fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < nd) frame[1+i] = tdata[i];
    end
    if (fmt.par_en) frame[4'd1 + nd] = par;
    nbits = 4'd2 + nd + {3'b000, fmt.par_en} + {3'b000, fmt.two_stop};
  end

  assign load = tick & ~hold & ~busy & have_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '1;
      cnt    <= '0;
      left   <= '0;
      tx_out <= 1'b1;
    end else if (hold) begin
      busy   <= 1'b0;
      cnt    <= '0;
      tx_out <= 1'b1;
    end else begin
      tx_out <= brk ? 1'b0 : (busy ? sh[0] : 1'b1);
      if (load) begin
        sh   <= frame;
        busy <= 1'b1;
        cnt  <= '0;
        left <= nbits;
      end else if (tick && busy) begin
        if (cnt == period - CW'(1)) begin
          cnt  <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R12
  break_holds_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !hold) |=> !tx_out);

  // R2
  hold_keeps_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> tx_out);
endmodule

// File: rtl/aser_regs.sv
module aser_regs
  import aser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_done,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       tx_load,
  output logic       mr,
  output div_t       div,
  output fmt_t       fmt,
  output logic       brk,
  output logic       tdr_full,
  output logic [7:0] tdr,
  output logic       irq
);
  logic [7:0] ctrl, rdr;
  logic       rx_full, ovr, pe, fe, tdr_empty;
  logic       rd_rx, wr_tdr, wr_ctl;

  assign wr_ctl   = bus_en &  bus_wr & ~bus_sel;
  assign wr_tdr   = bus_en &  bus_wr &  bus_sel;
  assign rd_rx    = bus_en & ~bus_wr &  bus_sel;
  assign div      = div_t'(ctrl[1:0]);
  assign mr       = (div == DIV_MRST);
  assign fmt      = fmt_decode(ctrl[4:2]);
  assign brk      = (ctrl[6:5] == 2'b11);
  assign tdr_full = ~tdr_empty;
  assign irq      = (ctrl[7] & (rx_full | ovr)) | ((ctrl[6:5] == 2'b01) & tdr_empty);
  assign bus_rdata = bus_sel ? rdr : {irq, pe, ovr, fe, 2'b00, tdr_empty, rx_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= 8'h03;
      rdr       <= '0;
      tdr       <= '0;
      rx_full   <= 1'b0;
      ovr       <= 1'b0;
      pe        <= 1'b0;
      fe        <= 1'b0;
      tdr_empty <= 1'b1;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata;
      if (mr) begin
        rx_full   <= 1'b0;
        ovr       <= 1'b0;
        pe        <= 1'b0;
        fe        <= 1'b0;
        tdr_empty <= 1'b1;
      end else begin
        if (rd_rx) begin
          rx_full <= 1'b0;
          ovr     <= 1'b0;
          pe      <= 1'b0;
          fe      <= 1'b0;
        end
        if (rx_done) begin
          if (rx_full && !rd_rx) begin
            ovr <= 1'b1;
          end else begin
            rdr     <= rx_data;
            rx_full <= 1'b1;
            pe      <= rx_perr;
            fe      <= rx_ferr;
          end
        end
        if (tx_load) tdr_empty <= 1'b1;
        if (wr_tdr) begin
          tdr       <= bus_wdata;
          tdr_empty <= 1'b0;
        end
      end
    end
  end

  // R5
  full_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done));

  // R9
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> (!rx_full && !ovr && !pe && !fe));

  // R11
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tdr && !mr) |=> !tdr_empty);

  // R2
  master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (tdr_empty && !rx_full && !ovr));
endmodule

// File: rtl/aser_adapter.sv
module aser_adapter
  import aser_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       rx_tick,
  input  logic       tx_tick,
  input  logic       rx_line,
  output logic       tx_line
);
  logic       mr, brk, tdr_full, tx_load;
  logic       rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data, tdr;
  div_t       div;
  fmt_t       fmt;

  aser_regs regs_i (
    .clk, .rst_n, .bus_en, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .rx_done, .rx_data, .rx_perr, .rx_ferr, .tx_load,
    .mr, .div, .fmt, .brk, .tdr_full, .tdr, .irq
  );

  aser_rx #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) rx_i (
    .clk, .rst_n, .hold(mr), .tick(rx_tick), .div,
    .eight(fmt.eight), .par_en(fmt.par_en), .par_odd(fmt.par_odd),
    .rx_in(rx_line), .done(rx_done), .data(rx_data),
    .par_err(rx_perr), .frm_err(rx_ferr)
  );

  aser_tx #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) tx_i (
    .clk, .rst_n, .hold(mr), .tick(tx_tick), .brk, .div, .fmt,
    .have_data(tdr_full), .tdata(tdr), .load(tx_load), .tx_out(tx_line)
  );
endmodule

// File: tb/aser_adapter_tb.sv
module aser_adapter_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       bus_en = 0, bus_wr = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       irq, tick = 1, rx_line = 1, tx_line;
  int         errors = 0, checks = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  aser_adapter dut_i (
    .clk, .rst_n, .bus_en, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .irq, .rx_tick(tick), .tx_tick(tick), .rx_line, .tx_line
  );

  // {format code [12:10], divide [9:8], data [7:0]}
  localparam logic [12:0] VEC [6] = '{
    {3'd5, 2'b01, 8'hA5}, {3'd6, 2'b00, 8'h3C}, {3'd7, 2'b01, 8'h81},
    {3'd0, 2'b10, 8'h55}, {3'd3, 2'b00, 8'h7F}, {3'd4, 2'b01, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk); bus_en = 1; bus_wr = 0; bus_sel = s; #1 v = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  // R3 format table
  task automatic fmt_info(input logic [2:0] c, output int nd, output bit pen, output bit podd, output bit two);
    nd = c[2] ? 8 : 7;
    case (c)
      3'd0: begin pen = 1; podd = 0; two = 1; end
      3'd1: begin pen = 1; podd = 1; two = 1; end
      3'd2: begin pen = 1; podd = 0; two = 0; end
      3'd3: begin pen = 1; podd = 1; two = 0; end
      3'd4: begin pen = 0; podd = 0; two = 1; end
      3'd5: begin pen = 0; podd = 0; two = 0; end
      3'd6: begin pen = 1; podd = 0; two = 0; end
      default: begin pen = 1; podd = 1; two = 0; end
    endcase
  endtask

  function automatic int ticks(input logic [1:0] dv);
    return dv == 2'b01 ? 16 : (dv == 2'b10 ? 64 : 1);
  endfunction

  task automatic hold_bit(input logic b, input int n);
    rx_line = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [2:0] c, input logic [1:0] dv, input logic [7:0] d,
                         input bit bad_par, input bit bad_stop);
    int nd, n; bit pen, podd, two; logic p;
    fmt_info(c, nd, pen, podd, two);
    n = ticks(dv);
    p = podd;
    @(negedge clk);
    hold_bit(0, n);
    for (int i = 0; i < nd; i++) begin
      hold_bit(d[i], n);
      p = p ^ d[i];
    end
    if (pen) hold_bit(p ^ bad_par, n);
    if (bad_stop) hold_bit(0, n / 2 + 2);
    hold_bit(1, n + 6);
  endtask

  task automatic tx_check(input logic [2:0] c, input logic [1:0] dv, input logic [7:0] d, input string req);
    int nd, n, k, bad; bit pen, podd, two; logic p;
    logic [11:0] exp_bits;
    fmt_info(c, nd, pen, podd, two);
    n = ticks(dv);
    p = podd; k = 0; bad = 0;
    exp_bits[k++] = 0;
    for (int i = 0; i < nd; i++) begin exp_bits[k++] = d[i]; p = p ^ d[i]; end
    if (pen) exp_bits[k++] = p;
    exp_bits[k++] = 1;
    wr(1, d);
    for (int w = 0; w < 200 && tx_line; w++) @(negedge clk);
    repeat (n / 2) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      if (tx_line !== exp_bits[i]) bad++;
      repeat (n) @(negedge clk);
    end
    check(req, bad, 0);
    repeat (2 * n + 4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [2:0] c; logic [1:0] dv; logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); check("R2 reset status", v, 8'h02);
    check("R2 reset line", tx_line, 1);
    check("R13 reset irq", irq, 0);
    wr(0, 8'h15);
    rd(0, v); check("R1 sel0 read is status", v, 8'h02);

    for (int t = 0; t < 6; t++) begin
      {c, dv, d} = VEC[t];
      wr(0, 8'h03);
      wr(0, {3'b000, c, dv});
      send_rx(c, dv, d, 0, 0);
      rd(0, v); check("R5 status after char", v, 8'h03);
      rd(1, v); check("R3 R5 received data", v, c[2] ? d : {1'b0, d[6:0]});
      tx_check(c, dv, d, "R4 transmit frame");
    end

    // parity error, 8E1 /16
    wr(0, 8'h19);
    send_rx(3'd6, 2'b01, 8'h5A, 1, 0);
    rd(0, v); check("R7 parity flag", v, 8'h43);
    rd(1, v); check("R7 data kept", v, 8'h5A);
    rd(0, v); check("R10 flags cleared", v, 8'h02);

    // framing error, 8N1 /16
    wr(0, 8'h15);
    send_rx(3'd5, 2'b01, 8'hC3, 0, 1);
    repeat (40) @(negedge clk);
    rd(0, v); check("R8 framing flag", v, 8'h13);
    rd(1, v);
    rd(0, v); check("R10 framing cleared", v, 8'h02);

    // overrun
    send_rx(3'd5, 2'b01, 8'h11, 0, 0);
    send_rx(3'd5, 2'b01, 8'h22, 0, 0);
    rd(0, v); check("R9 overrun flag", v, 8'h23);
    rd(1, v); check("R9 first char kept", v, 8'h11);
    rd(0, v); check("R10 overrun cleared", v, 8'h02);

    // glitch rejection
    @(negedge clk); hold_bit(0, 3); hold_bit(1, 60);
    rd(0, v); check("R6 glitch ignored", v, 8'h02);
    send_rx(3'd5, 2'b01, 8'h6E, 0, 0);
    rd(1, v); check("R6 char after glitch", v, 8'h6E);

    // receive interrupt
    wr(0, 8'h95);
    check("R13 irq idle", irq, 0);
    send_rx(3'd5, 2'b01, 8'h99, 0, 0);
    check("R13 irq on receive", irq, 1);
    rd(0, v); check("R13 status bit7", v, 8'h83);
    rd(1, v);
    @(negedge clk); check("R13 irq after read", irq, 0);

    // transmit interrupt and empty flag
    wr(0, 8'h35);
    check("R13 tx irq", irq, 1);
    tick = 0;
    wr(1, 8'h4D);
    rd(0, v); check("R11 write clears empty", v, 8'h00);
    tick = 1;
    repeat (4) @(negedge clk);
    rd(0, v); check("R11 empty after load", v, 8'h82);
    repeat (220) @(negedge clk);

    // break
    wr(0, 8'h75);
    begin
      int hi = 0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 40; i++) begin
        if (tx_line) hi++;
        @(negedge clk);
      end
      check("R12 break holds space", hi, 0);
    end
    wr(0, 8'h15);
    repeat (3) @(negedge clk);
    check("R12 line back to mark", tx_line, 1);

    // master reset
    send_rx(3'd5, 2'b01, 8'h77, 0, 0);
    wr(0, 8'h03);
    rd(0, v); check("R2 master reset clears", v, 8'h02);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule